// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block models a synchronous static RAM whose data bus can switch between reads and writes on every clock with no idle cycle in between. The address, control and byte enables are registered on the rising clock edge. The write data for an operation is taken later than its address: two edges later in pipelined mode and one edge later in flow-through mode. Because of this offset, a read's data and a write's data occupy the bus in the same relative cycle, so any mix of reads and writes runs at full rate.

Bursts of four beats are started by a normal access and continued with an advance input. The burst order can be linear or interleaved. Each 9-bit byte lane has its own write enable and its own parity check. Three chip enables qualify each new access. An asynchronous output enable can force the data outputs off at any time. The bidirectional bus is split into separate data-in and data-out ports, plus a drive-enable output.

A read that targets a word whose write data has not yet reached the array returns the pending bytes merged with the stored bytes.

Top module: `latewr_sram`

## Requirements
- R1: A new access is accepted on a rising edge only when `adv` is 0, `cs_a` is 1, `cs_b` is 1 and `cs_c_n` is 0. In any other case with `adv` at 0, that cycle performs no read and no write.
- R2: In pipelined mode (`flow_mode` = 0), a read accepted at edge N drives its word on `rdata`, with `rdata_oe` = 1, in the cycle that follows edge N+1, and not earlier.
- R3: In pipelined mode, the write data for a write accepted at edge N is taken from `wdata` at edge N+2. Values on `wdata` at other edges do not affect that word.
- R4: In flow-through mode (`flow_mode` = 1), a read accepted at edge N drives its word in the cycle that follows edge N. The write data for a write accepted at edge N is taken at edge N+1.
- R5: Reads and writes can be issued on consecutive edges in any order. In the output slot that belongs to a write, `rdata_oe` is 0.
- R6: In pipelined mode, a read of the word written by the immediately preceding access returns the new data of that write. The new data is used only for lanes whose enable bit was set; the other lanes come from the array.
- R7: With `adv` = 1 on the edges after an accepted access, the burst continues with the same direction. With `interleave` = 0, address bits [1:0] of beat k are (start + k) mod 4, and the upper bits are unchanged.
- R8: With `interleave` = 1, address bits [1:0] of beat k are the start bits XOR k.
- R9: Byte-enable bit l covers `wdata`/`rdata` bits [9l+8:9l]. A lane whose bit is 0 keeps its stored value.
- R10: Each enabled lane of write data is checked when it is sampled. `par_err[l]` is 1 for exactly the following cycle if the XOR of the lane's 9 bits differs from `odd_par` (0 = even parity, 1 = odd parity). The faulty lane is still written. Disabled lanes are not flagged.
- R11: `oe_n` = 1 forces `rdata_oe` to 0 and `rdata` to zero at once, without waiting for a clock edge. `rdata` is zero whenever `rdata_oe` is 0.
- R12: After reset, `rdata_oe` and `par_err` are 0 and no access is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control pipeline |
| flow_mode | input | 1 | 1 = flow-through, 0 = pipelined; held steady outside reset |
| interleave | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| odd_par | input | 1 | Parity sense: 1 = odd, 0 = even |
| cs_a | input | 1 | Chip enable, active high |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Continue the current burst |
| wr | input | 1 | 1 = write, 0 = read for a new access |
| addr | input | ADDR_W | Word address |
| byte_en | input | LANES | Per-lane write enable, sampled with each address |
| wdata | input | LANES*LANE_W | Late write data |
| oe_n | input | 1 | Asynchronous output disable, active high |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Output driver enable |
| par_err | output | LANES | Per-lane write parity error, one cycle |

## Verification
The bench uses the default build: a 6-bit word address (64 words), four lanes, and 9 bits per lane. With 64 words, both burst orders can wrap inside one aligned group of four words while other words stay untouched as controls. With four lanes, a mask such as 0101 mixes forwarded lanes and stored lanes in one read word. Parity faults can be placed in a single lane, and in disabled lanes. Both latency modes are reached by resetting with `flow_mode` changed.

// File: rtl/latewr_pkg.sv
package latewr_pkg;
   localparam int BURST_W = 2;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;
endpackage

// File: rtl/latewr_burst.sv
module latewr_burst #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              interleave,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int BW = latewr_pkg::BURST_W;

   logic [ADDR_W-1:0] base_q;
   logic [BW-1:0]     beat_q;
   logic [BW-1:0]     low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
      end else if (load) begin
         base_q <= addr_in;
         beat_q <= '0;
      end else if (step) begin
         beat_q <= beat_q + 1'b1;
      end
   end

   always_comb begin
      if (interleave) low = base_q[BW-1:0] ^ beat_q;
      else            low = base_q[BW-1:0] + beat_q;
   end

   assign addr_out = {base_q[ADDR_W-1:BW], low};
endmodule

// File: rtl/latewr_array.sv
module latewr_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                     clk,
   input  logic [LANES-1:0]         we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [LANES*LANE_W-1:0]  wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [LANES*LANE_W-1:0]  rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
      assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
   end
endmodule

// File: rtl/latewr_parity.sv
module latewr_parity #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    chk_en,
   input  logic [LANES-1:0]        lane_en,
   input  logic                    odd_par,
   input  logic [LANES*LANE_W-1:0] data,
   output logic [LANES-1:0]        err
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic bad;
      assign bad = (^data[g*LANE_W +: LANE_W]) != odd_par;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err[g] <= 1'b0;
         else        err[g] <= chk_en & lane_en[g] & bad;
      end
   end
endmodule

// File: rtl/latewr_sram.sv
module latewr_sram #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_mode,
   input  logic              interleave,
   input  logic              odd_par,
   input  logic              cs_a,
   input  logic              cs_b,
   input  logic              cs_c_n,
   input  logic              adv,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  byte_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              oe_n,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   output logic [LANES-1:0]  par_err
);
   import latewr_pkg::*;

   if (ADDR_W < BURST_W) begin : g_bad_addr
      $error("ADDR_W must cover the burst bits");
   end
   if (LANES < 1 || LANE_W < 2) begin : g_bad_lane
      $error("LANES must be >= 1 and LANE_W >= 2");
   end

   logic sel, start, step;
   logic live_q, burst_wr_q;
   op_e  s1_op, s2_op, cm_op;
   logic [ADDR_W-1:0] s1_addr, s2_addr, cm_addr;
   logic [LANES-1:0]  s1_be, s2_be, cm_be;
   logic [LANES-1:0]  arr_we;
   logic [DATA_W-1:0] arr_rd, merged, out_q;
   logic out_vld_q, fwd_hit, drive, cm_is_wr;

   assign sel   = cs_a & cs_b & ~cs_c_n;
   assign start = ~adv & sel;
   assign step  = adv & live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q     <= 1'b0;
         burst_wr_q <= 1'b0;
         s1_op      <= OP_IDLE;
         s1_be      <= '0;
         s2_op      <= OP_IDLE;
         s2_addr    <= '0;
         s2_be      <= '0;
      end else begin
         live_q <= start | step;
         if (start) burst_wr_q <= wr;
         if (start)     s1_op <= wr ? OP_WR : OP_RD;
         else if (step) s1_op <= burst_wr_q ? OP_WR : OP_RD;
         else           s1_op <= OP_IDLE;
         s1_be   <= byte_en;
         s2_op   <= s1_op;
         s2_addr <= s1_addr;
         s2_be   <= s1_be;
      end
   end

   latewr_burst #(.ADDR_W(ADDR_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .load(start), .step(step),
      .interleave(interleave), .addr_in(addr), .addr_out(s1_addr)
   );

   // commit point: one edge late in flow-through, two in pipelined
   assign cm_op    = flow_mode ? s1_op   : s2_op;
   assign cm_addr  = flow_mode ? s1_addr : s2_addr;
   assign cm_be    = flow_mode ? s1_be   : s2_be;
   assign cm_is_wr = (cm_op == OP_WR);
   assign arr_we   = cm_is_wr ? cm_be : '0;

   latewr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .we(arr_we), .waddr(cm_addr), .wdata(wdata),
      .raddr(s1_addr), .rdata(arr_rd)
   );

   latewr_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_parity (
      .clk(clk), .rst_n(rst_n), .chk_en(cm_is_wr), .lane_en(cm_be),
      .odd_par(odd_par), .data(wdata), .err(par_err)
   );

   // pipelined read meets the write whose data lands on this same edge
   assign fwd_hit = ~flow_mode & (s2_op == OP_WR) & (s2_addr == s1_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_merge
      assign merged[g*LANE_W +: LANE_W] = (fwd_hit & s2_be[g]) ?
             wdata[g*LANE_W +: LANE_W] : arr_rd[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q     <= '0;
         out_vld_q <= 1'b0;
      end else begin
         out_vld_q <= (s1_op == OP_RD);
         if (s1_op == OP_RD) out_q <= merged;
      end
   end

   assign drive    = flow_mode ? (s1_op == OP_RD) : out_vld_q;
   assign rdata_oe = drive & ~oe_n;
   assign rdata    = rdata_oe ? (flow_mode ? arr_rd : out_q) : '0;
endmodule

// File: rtl/latewr_sram_chk.sv
module latewr_sram_chk #(
   parameter int LANES  = 4,
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flow_mode,
   input logic              cs_a,
   input logic              cs_b,
   input logic              cs_c_n,
   input logic              adv,
   input logic              wr,
   input logic              oe_n,
   input logic [DATA_W-1:0] rdata,
   input logic              rdata_oe,
   input logic [LANES-1:0]  par_err,
   input logic              cm_is_wr
);
   logic acc;
   assign acc = ~adv & cs_a & cs_b & ~cs_c_n;

   // R1
   desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode && !adv && !(cs_a && cs_b && !cs_c_n)) |=> !rdata_oe);

   // R2
   pipe_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_mode && acc && !wr) |-> ##2 (rdata_oe || oe_n));

   // R4
   flow_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode && acc && !wr) |=> (rdata_oe || oe_n));

   // R5
   pipe_wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_mode && acc && wr) |-> ##2 !rdata_oe);

   // R5
   flow_wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode && acc && wr) |=> !rdata_oe);

   // R10
   par_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|par_err) |-> $past(cm_is_wr));

   // R11
   oe_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rdata_oe);

   // R11
   bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> (rdata == '0));
endmodule

bind latewr_sram latewr_sram_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .cs_a(cs_a), .cs_b(cs_b),
   .cs_c_n(cs_c_n), .adv(adv), .wr(wr), .oe_n(oe_n), .rdata(rdata),
   .rdata_oe(rdata_oe), .par_err(par_err), .cm_is_wr(cm_is_wr)
);

// File: tb/latewr_sram_tb.sv
module latewr_sram_tb_top;
   localparam int OP_IDLE = 0;
   localparam int OP_RD   = 1;
   localparam int OP_WR   = 2;
   localparam int OP_ADV  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flow_mode = 1'b0, interleave = 1'b0, odd_par = 1'b0;
   logic cs_a = 1'b0, cs_b = 1'b0, cs_c_n = 1'b1;
   logic adv = 1'b0, wr = 1'b0, oe_n = 1'b0;
   logic [5:0]  addr = '0;
   logic [3:0]  byte_en = '0;
   logic [35:0] wdata = '0;
   logic [35:0] rdata;
   logic        rdata_oe;
   logic [3:0]  par_err;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   latewr_sram dut_i (
      .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .interleave(interleave),
      .odd_par(odd_par), .cs_a(cs_a), .cs_b(cs_b), .cs_c_n(cs_c_n), .adv(adv),
      .wr(wr), .addr(addr), .byte_en(byte_en), .wdata(wdata), .oe_n(oe_n),
      .rdata(rdata), .rdata_oe(rdata_oe), .par_err(par_err)
   );

   function automatic logic [35:0] mkw(input logic [31:0] v, input logic odd);
      logic [35:0] r;
      for (int l = 0; l < 4; l++) begin
         r[9*l +: 9] = {(^v[8*l +: 8]) ^ odd, v[8*l +: 8]};
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int op, input logic [5:0] a, input logic [3:0] be,
                      input logic [35:0] wd);
      cs_a = 1'b1; cs_b = 1'b1; cs_c_n = 1'b0; adv = 1'b0;
      case (op)
         OP_IDLE: cs_a = 1'b0;
         OP_RD:   wr = 1'b0;
         OP_WR:   wr = 1'b1;
         default: adv = 1'b1;
      endcase
      addr = a; byte_en = be; wdata = wd;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_reset(input logic fm);
      rst_n = 1'b0;
      cs_a = 1'b0; adv = 1'b0;
      flow_mode = fm;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset(1'b0);
      chk("R12 oe", {35'd0, rdata_oe}, 36'd0);
      chk("R12 par", {32'd0, par_err}, 36'd0);
      chk("R12 data", rdata, 36'd0);
   endtask

   task automatic t_pipe_mix();
      logic [35:0] da, db;
      da = mkw(32'h11223344, 1'b0);
      db = mkw(32'h55667788, 1'b0);
      cyc(OP_WR, 6'd8, 4'hF, '0);
      cyc(OP_RD, 6'd8, 4'hF, '0);
      cyc(OP_WR, 6'd12, 4'hF, da);
      chk("R6 forward read-after-write", rdata, da);
      chk("R2 oe on read slot", {35'd0, rdata_oe}, 36'd1);
      cyc(OP_RD, 6'd12, 4'hF, '0);
      chk("R5 write slot undriven", {35'd0, rdata_oe}, 36'd0);
      cyc(OP_IDLE, 6'd0, 4'h0, db);
      chk("R3 data two edges late", rdata, db);
      cyc(OP_RD, 6'd8, 4'hF, '0);
      chk("R2 not before second edge", {35'd0, rdata_oe}, 36'd0);
      cyc(OP_IDLE, 6'd0, 4'h0, '0);
      chk("R2 array read", rdata, da);
   endtask

   task automatic t_merge();
      logic [35:0] dc, dd, ex;
      dc = mkw(32'hA1A2A3A4, 1'b0);
      dd = mkw(32'hB1B2B3B4, 1'b0);
      ex = {dc[35:27], dd[26:18], dc[17:9], dd[8:0]};
      cyc(OP_WR, 6'd20, 4'hF, '0);
      cyc(OP_IDLE, 6'd0, 4'h0, '0);
      cyc(OP_IDLE, 6'd0, 4'h0, dc);
      cyc(OP_WR, 6'd20, 4'b0101, '0);
      cyc(OP_RD, 6'd20, 4'hF, '0);
      cyc(OP_IDLE, 6'd0, 4'h0, dd);
      chk("R6 merged forward", rdata, ex);
      cyc(OP_RD, 6'd20, 4'hF, '0);
      cyc(OP_IDLE, 6'd0, 4'h0, '0);
      chk("R9 masked lanes kept", rdata, ex);
   endtask

   task automatic t_burst();
      logic [35:0] v [4];
      for (int i = 0; i < 4; i++) v[i] = mkw(32'hC0000000 + i * 32'h01010101, 1'b0);
      cyc(OP_WR, 6'd32, 4'hF, '0);
      cyc(OP_WR, 6'd33, 4'hF, '0);
      cyc(OP_WR, 6'd34, 4'hF, v[0]);
      cyc(OP_WR, 6'd35, 4'hF, v[1]);
      cyc(OP_IDLE, 6'd0, 4'h0, v[2]);
      cyc(OP_IDLE, 6'd0, 4'h0, v[3]);
      interleave = 1'b0;
      cyc(OP_RD, 6'd34, 4'hF, '0);
      cyc(OP_ADV, 6'd0, 4'hF, '0);
      chk("R7 linear beat0", rdata, v[2]);
      cyc(OP_ADV, 6'd0, 4'hF, '0);
      chk("R7 linear beat1", rdata, v[3]);
      cyc(OP_ADV, 6'd0, 4'hF, '0);
      chk("R7 linear beat2 wrap", rdata, v[0]);
      cyc(OP_IDLE, 6'd0, 4'h0, '0);
      chk("R7 linear beat3", rdata, v[1]);
      interleave = 1'b1;
      cyc(OP_RD, 6'd33, 4'hF, '0);
      cyc(OP_ADV, 6'd0, 4'hF, '0);
      chk("R8 interleaved beat0", rdata, v[1]);
      cyc(OP_ADV, 6'd0, 4'hF, '0);
      chk("R8 interleaved beat1", rdata, v[0]);
      cyc(OP_ADV, 6'd0, 4'hF, '0);
      chk("R8 interleaved beat2", rdata, v[3]);
      cyc(OP_IDLE, 6'd0, 4'h0, '0);
      chk("R8 interleaved beat3", rdata, v[2]);
      interleave = 1'b0;
   endtask

   task automatic t_flow();
      logic [35:0] e0, e1, e2;
      e0 = mkw(32'h0F1E2D3C, 1'b0);
      e1 = mkw(32'h4B5A6978, 1'b0);
      e2 = mkw(32'hDEADBEEF, 1'b0);
      do_reset(1'b1);
      cyc(OP_WR, 6'd5, 4'hF, '0);
      cyc(OP_RD, 6'd5, 4'hF, e0);
      chk("R4 flow single late write and read", rdata, e0);
      cyc(OP_WR, 6'd6, 4'hF, '0);
      chk("R5 flow write slot undriven", {35'd0, rdata_oe}, 36'd0);
      cyc(OP_IDLE, 6'd0, 4'h0, e1);
      cyc(OP_RD, 6'd6, 4'hF, '0);
      chk("R4 flow read", rdata, e1);
      cs_a = 1'b1; cs_b = 1'b1; cs_c_n = 1'b1; adv = 1'b0; wr = 1'b0; addr = 6'd5;
      @(posedge clk); @(negedge clk);
      chk("R1 inactive low enable blocks read", {35'd0, rdata_oe}, 36'd0);
      cs_c_n = 1'b0; cs_b = 1'b0; wr = 1'b1; byte_en = 4'hF;
      @(posedge clk); @(negedge clk);
      cyc(OP_IDLE, 6'd0, 4'h0, e2);
      cyc(OP_RD, 6'd5, 4'hF, '0);
      chk("R1 deselected write ignored", rdata, e0);
   endtask

   task automatic t_parity();
      logic [35:0] pb, g1, g0;
      pb = mkw(32'h0A0B0C0D, 1'b0) ^ (36'h1 << 26);
      odd_par = 1'b0;
      cyc(OP_WR, 6'd7, 4'hF, '0);
      cyc(OP_IDLE, 6'd0, 4'h0, pb);
      chk("R10 even lane2 flag", {32'd0, par_err}, 36'h4);
      cyc(OP_IDLE, 6'd0, 4'h0, '0);
      chk("R10 flag one cycle", {32'd0, par_err}, 36'h0);
      cyc(OP_RD, 6'd7, 4'hF, '0);
      chk("R10 bad byte still written", rdata, pb);
      odd_par = 1'b1;
      g1 = mkw(32'h12345678, 1'b1);
      g0 = mkw(32'h9ABCDEF0, 1'b0);
      cyc(OP_WR, 6'd9, 4'hF, '0);
      cyc(OP_WR, 6'd10, 4'b0011, g1);
      chk("R10 odd good no flag", {32'd0, par_err}, 36'h0);
      cyc(OP_IDLE, 6'd0, 4'h0, g0);
      chk("R10 odd flags enabled lanes only", {32'd0, par_err}, 36'h3);
      odd_par = 1'b0;
      cyc(OP_IDLE, 6'd0, 4'h0, '0);
   endtask

   task automatic t_oe();
      cyc(OP_RD, 6'd7, 4'hF, '0);
      chk("R11 oe before", {35'd0, rdata_oe}, 36'd1);
      oe_n = 1'b1;
      #1;
      chk("R11 async off", {35'd0, rdata_oe}, 36'd0);
      chk("R11 data zero", rdata, 36'd0);
      oe_n = 1'b0;
      #1;
      chk("R11 restored", {35'd0, rdata_oe}, 36'd1);
      cyc(OP_IDLE, 6'd0, 4'h0, '0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_pipe_mix();
      t_merge();
      t_burst();
      t_flow();
      t_parity();
      t_oe();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule